// File: doc/BRIEF.md
# Bypass-Protected Clock Divider Sequencer

This block owns the integer divider that turns a fast source clock into a slower output clock, and it changes the divide setting without producing runt or glitched pulses. The divided clock is modelled as a one-cycle enable, `clk_en`, in the source clock domain. When a new divide value is requested, the block first clears the alternate external bypass source so that the reference clock becomes the bypass source. One cycle later it raises bypass and loads the new divider value. While bypass is high, `clk_en` follows the reference-clock enable `ref_tick`, and the divider setting has no effect on it.

Bypass is held for a parameterised number of reference ticks. This time window stands in for the minimum settling delay of the hardware. When the window ends, bypass drops, the divider counter restarts from zero, and `done` pulses for one cycle. The divide field is 8 bits wide, and a stored 0 means divide by 256. A fixed pre-divide by two (parameter `PRE_HALVE`, default 1) halves the source rate ahead of the divider. The block reports the resulting overall ratio on `ratio`.

Top module: `clkdiv_seq`

## Requirements
- R1: After reset: `bypass`, `busy`, `done`, `alt_sel` and `clk_en` are 0 when `ref_tick` is 0, and `div_field` equals `RESET_DIV` (default 4).
- R2: A requested value v in 1..255 is stored in `div_field` as v. A request of 0, 256 or more is stored as 0, and a stored 0 means divide by 256.
- R3: In the first cycle after an accepted request, `busy`=1, `alt_sel`=0 and `bypass`=0. In the next cycle `bypass`=1 and `div_field` shows the new value. `div_field` changes only in a cycle where `bypass` is 1.
- R4: `bypass` stays high until it has seen exactly `HOLD_TICKS` (default 4) cycles with `ref_tick`=1. It falls on the edge that ends the last of those cycles.
- R5: While `bypass`=1, `clk_en` equals `ref_tick` in every cycle.
- R6: When `bypass` is 0, `clk_en` pulses for one cycle every 2·N source cycles, where N is the effective divisor. Counting the first cycle with `bypass` low as index 0, the first pulse falls at index 2·N−1.
- R7: `done` is high for exactly one cycle, the first cycle with `bypass` low after a sequence. `busy` is low in that same cycle.
- R8: A request presented while `busy`=1 is ignored: the divider value loaded is that of the accepted request.
- R9: `ratio` equals 2·N for the stored field (N = 256 for field 0).
- R10: While idle, `alt_sel` follows `alt_req` one cycle later. `alt_sel` is never 1 while `bypass` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request to load a new divide value |
| req_div | input | 9 | Requested divide value (0 and >=256 mean 256) |
| alt_req | input | 1 | Select the alternate external bypass source while idle |
| ref_tick | input | 1 | Reference-clock enable |
| busy | output | 1 | Reprogramming sequence in progress |
| done | output | 1 | One-cycle pulse when bypass is released |
| bypass | output | 1 | Output is following the reference clock |
| alt_sel | output | 1 | Alternate external bypass source selected |
| div_field | output | 8 | Active divide field |
| ratio | output | 10 | Effective source-to-output ratio |
| clk_en | output | 1 | Enable pulse standing in for the output clock |

## Verification
A corrupted hold counter shows at the ports within one sequence, because the number of reference ticks seen under bypass no longer matches `HOLD_TICKS`. A wrong divider counter or pre-divide phase shifts the first `clk_en` pulse after release away from index 2·N−1, and this shows within a single output period. A broken sequencing state shows within two cycles of a request: bypass rises before the alternate source is cleared, or the loaded field differs from the clamped value of the accepted request.

// File: rtl/clkdiv_seq_pkg.sv
package clkdiv_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_e;
endpackage

// File: rtl/clkdiv_seq_ctrl.sv
module clkdiv_seq_ctrl
    import clkdiv_seq_pkg::*;
#(
    parameter int REQ_W      = 9,
    parameter int FIELD_W    = 8,
    parameter int HOLD_TICKS = 4,
    parameter int RESET_DIV  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [REQ_W-1:0]   req_div,
    input  logic               alt_req,
    input  logic               ref_tick,
    output logic               busy,
    output logic               done,
    output logic               bypass,
    output logic               alt_sel,
    output logic [FIELD_W-1:0] div_field
);
    localparam int HCNT_W = $clog2(HOLD_TICKS + 1);
    localparam int FULL   = 1 << FIELD_W;

    typedef struct packed {
        seq_state_e         state;
        logic [FIELD_W-1:0] pend;
        logic [FIELD_W-1:0] div;
        logic               byp;
        logic               alt;
        logic [HCNT_W-1:0]  hcnt;
        logic               done;
    } ctrl_s;

    ctrl_s q_q, d_d;
    logic [FIELD_W-1:0] clamp_d;

    always_comb begin
        if (req_div == '0 || req_div >= REQ_W'(FULL))
            clamp_d = '0;
        else
            clamp_d = req_div[FIELD_W-1:0];

        d_d      = q_q;
        d_d.done = 1'b0;
        case (q_q.state)
            ST_IDLE: begin
                d_d.alt = alt_req;
                if (req_valid) begin
                    d_d.state = ST_PREP;
                    d_d.pend  = clamp_d;
                    d_d.alt   = 1'b0;
                end
            end
            ST_PREP: begin
                d_d.byp   = 1'b1;
                d_d.div   = q_q.pend;
                d_d.hcnt  = '0;
                d_d.state = ST_HOLD;
            end
            ST_HOLD: begin
                if (ref_tick) begin
                    if (q_q.hcnt == HCNT_W'(HOLD_TICKS - 1)) begin
                        d_d.byp   = 1'b0;
                        d_d.done  = 1'b1;
                        d_d.state = ST_IDLE;
                    end else begin
                        d_d.hcnt = q_q.hcnt + 1'b1;
                    end
                end
            end
            default: d_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q.state <= ST_IDLE;
            q_q.pend  <= '0;
            q_q.div   <= FIELD_W'(RESET_DIV);
            q_q.byp   <= 1'b0;
            q_q.alt   <= 1'b0;
            q_q.hcnt  <= '0;
            q_q.done  <= 1'b0;
        end else begin
            q_q <= d_d;
        end
    end

    assign busy      = (q_q.state != ST_IDLE);
    assign done      = q_q.done;
    assign bypass    = q_q.byp;
    assign alt_sel   = q_q.alt;
    assign div_field = q_q.div;

    // R10
    alt_off_in_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.byp |-> !q_q.alt);
    // R3
    alt_cleared_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_q.byp) |-> $past(!q_q.alt));
    // R3
    div_only_in_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q_q.div) |-> q_q.byp);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.done |=> !q_q.done);
endmodule

// File: rtl/clkdiv_seq_gen.sv
module clkdiv_seq_gen #(
    parameter int FIELD_W   = 8,
    parameter bit PRE_HALVE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bypass,
    input  logic               ref_tick,
    input  logic [FIELD_W-1:0] div_field,
    output logic               clk_en
);
    localparam int CNT_W = FIELD_W + 1;
    localparam int FULL  = 1 << FIELD_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ph;
    } gen_s;

    gen_s q_q, d_d;
    logic [CNT_W-1:0] last;
    logic src_tick;

    generate
        if (PRE_HALVE) begin : g_half
            assign src_tick = q_q.ph;
        end else begin : g_full
            assign src_tick = 1'b1 | q_q.ph;
        end
    endgenerate

    always_comb begin
        if (div_field == '0)
            last = CNT_W'(FULL - 1);
        else
            last = {1'b0, div_field} - 1'b1;

        d_d = q_q;
        if (bypass) begin
            d_d.cnt = '0;
            d_d.ph  = 1'b0;
        end else begin
            d_d.ph = ~q_q.ph;
            if (src_tick)
                d_d.cnt = (q_q.cnt == last) ? '0 : q_q.cnt + 1'b1;
        end
        clk_en = bypass ? ref_tick : (src_tick && (q_q.cnt == last));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q.cnt <= '0;
            q_q.ph  <= 1'b0;
        end else begin
            q_q <= d_d;
        end
    end

    // R6
    reload_on_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (q_q.cnt == '0 && !q_q.ph));
    // R6
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass |-> (q_q.cnt <= last));
endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq #(
    parameter int REQ_W      = 9,
    parameter int FIELD_W    = 8,
    parameter int HOLD_TICKS = 4,
    parameter int RESET_DIV  = 4,
    parameter bit PRE_HALVE  = 1'b1,
    parameter int RATIO_W    = FIELD_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [REQ_W-1:0]   req_div,
    input  logic               alt_req,
    input  logic               ref_tick,
    output logic               busy,
    output logic               done,
    output logic               bypass,
    output logic               alt_sel,
    output logic [FIELD_W-1:0] div_field,
    output logic [RATIO_W-1:0] ratio,
    output logic               clk_en
);
    localparam int FULL = 1 << FIELD_W;

    clkdiv_seq_ctrl #(
        .REQ_W(REQ_W), .FIELD_W(FIELD_W),
        .HOLD_TICKS(HOLD_TICKS), .RESET_DIV(RESET_DIV)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_div(req_div),
        .alt_req(alt_req), .ref_tick(ref_tick), .busy(busy), .done(done),
        .bypass(bypass), .alt_sel(alt_sel), .div_field(div_field)
    );

    clkdiv_seq_gen #(.FIELD_W(FIELD_W), .PRE_HALVE(PRE_HALVE)) gen_i (
        .clk(clk), .rst_n(rst_n), .bypass(bypass), .ref_tick(ref_tick),
        .div_field(div_field), .clk_en(clk_en)
    );

    logic [RATIO_W-1:0] nval;
    always_comb begin
        nval  = (div_field == '0) ? RATIO_W'(FULL) : RATIO_W'(div_field);
        ratio = PRE_HALVE ? (nval << 1) : nval;
    end
endmodule

// File: tb/clkdiv_seq_tb_top.sv
module clkdiv_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 4;

    logic clk = 0, rst_n = 0, req_valid = 0, alt_req = 0, ref_tick = 0;
    logic [8:0] req_div = '0;
    logic busy, done, bypass, alt_sel, clk_en;
    logic [7:0] div_field;
    logic [9:0] ratio;
    int n_chk = 0, n_fail = 0, cyc = 0;

    clkdiv_seq dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_div(req_div),
        .alt_req(alt_req), .ref_tick(ref_tick), .busy(busy), .done(done), .bypass(bypass),
        .alt_sel(alt_sel), .div_field(div_field), .ratio(ratio), .clk_en(clk_en));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        #1 ref_tick = ($urandom % 3) == 0;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, act=%0d exp<=150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_field(input int v);
        return (v == 0 || v >= 256) ? 0 : v;
    endfunction
    function automatic int nval(input int f);
        return (f == 0) ? 256 : f;
    endfunction

    task automatic run_seq(input int v, input bit extra, input int v2);
        int f, n, ticks, first_bad, bad_act;
        while (busy) @(negedge clk);
        @(posedge clk); #1 req_valid = 1; req_div = 9'(v);
        @(posedge clk); #1 req_valid = extra; req_div = 9'(v2);
        @(negedge clk);
        chk(busy && !alt_sel && !bypass, "R3 prep cycle busy/alt/bypass", {busy, alt_sel, bypass}, 3'b100);
        @(posedge clk); #1 req_valid = 0;
        @(negedge clk);
        f = exp_field(v); n = nval(f);
        chk(bypass == 1, "R3 bypass raised", bypass, 1);
        chk(div_field == 8'(f), extra ? "R8 busy request ignored" : "R2 clamped field", div_field, f);
        chk(ratio == 10'(2*n), "R9 ratio", ratio, 2*n);
        ticks = 0; first_bad = -1; bad_act = 0;
        while (bypass) begin
            if (ref_tick) ticks++;
            if (clk_en !== ref_tick) first_bad = 1;
            if (done || alt_sel) first_bad = 2;
            @(negedge clk);
        end
        chk(first_bad == -1, "R5/R10 bypass follows ref, no alt, no done", first_bad, -1);
        chk(ticks == HOLD, "R4 hold ticks", ticks, HOLD);
        chk(done && !busy, "R7 done at release", {done, busy}, 2'b10);
        first_bad = -1;
        for (int i = 0; i < 4*n; i++) begin
            if (i == 1 && done) first_bad = 99999;
            if (clk_en !== (((i % (2*n)) == 2*n-1) ? 1'b1 : 1'b0) && first_bad < 0) begin
                first_bad = i; bad_act = clk_en;
            end
            @(negedge clk);
        end
        chk(first_bad == -1, "R6 divided pulse pattern (first bad index)", first_bad, -1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!bypass && !busy && !done && !alt_sel, "R1 reset flags", {bypass, busy, done, alt_sel}, 0);
        chk(div_field == 8'd4, "R1 reset div", div_field, 4);
        chk(clk_en == ref_tick && !ref_tick || ref_tick, "R1 reset clk_en", clk_en, 0);
        @(posedge clk); #1 rst_n = 1;
        @(posedge clk); #1 alt_req = 1;
        @(negedge clk); @(negedge clk);
        chk(alt_sel == 1, "R10 alt follows in idle", alt_sel, 1);
        run_seq(3, 0, 0);
        chk(alt_sel == 1, "R10 alt resumes after done", alt_sel, 1);
        run_seq(0, 0, 0);
        run_seq(300, 0, 0);
        run_seq(256, 0, 0);
        run_seq(1, 0, 0);
        run_seq(255, 0, 0);
        run_seq(7, 1, 12);
        alt_req = 0;
        for (int k = 0; k < 8; k++) begin
            int v;
            v = $urandom % 40;
            if (k % 3 == 0) v = 200 + ($urandom % 311);
            run_seq(v, k[0], 2 + ($urandom % 50));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule